// File: doc/BRIEF.md
# Round-Robin Transmit Interrupt Scanner

This block keeps per-line transmit interrupt state for a character multiplexer with up to 64 lines, of which a run-time count is in use. Each line holds an armed flag and a request flag. A send command arms a line. When that line's character completes, the line raises a request. A search then walks the active lines in circular order, starting just past the current pointer. It stops at the first line with a request, moves the pointer there, takes a lock and pulses one shared interrupt.

The host reads the pointer through a strobed read port. The returned value is the line number with bit 6 set as a fixed marker. The same read clears that line's request. The lock is released only by a later send or stop command, which clears the lock and then searches again. A completion event seen while the lock is held sets its line's request but does not search. That request waits until a command unlocks the scanner.

Every event input is a single-cycle strobe with no back-pressure, so the block never stalls its sources. `rd_data` is combinational from the pointer and is valid in every cycle. `rd_en` only adds the side effect of clearing a request.

Top module: `txirq_scanner`

## Requirements
- R1: Reset clears every armed flag, every request flag, the pointer and the lock. After reset `irq` is 0 and `rd_data` reads 0x40.
- R2: A command with `cmd_op` = 2'b01 (send) on an active line arms that line and clears its request. It then clears the lock and searches.
- R3: A command with `cmd_op` = 2'b10 (stop) on an active line disarms that line and clears its request. It then clears the lock and searches. Codes 2'b00 and 2'b11 have no effect.
- R4: A completion on an active, armed line sets that line's request. A completion on an unarmed line changes nothing and starts no search.
- R5: A search visits the lines in this order: pointer+1, pointer+2, and so on, wrapping to 0 after the last active line. It covers at most one full cycle of active lines, with the current pointer line examined last. It stops at the first line whose request is set, using the request values after this cycle's updates.
- R6: When a search finds a line, the pointer moves to that line and the lock is set. `irq` is high for exactly the one cycle after that clock edge.
- R7: While the lock is set, a completion event does not search and does not move the pointer. Only a command clears the lock; a host read does not.
- R8: `rd_data` equals 0x40 OR the pointer, zero-extended to 8 bits. `rd_en` clears the request of the pointed line. A completion setting the same line in the same cycle takes precedence over the clear.
- R9: The active count is `num_active`, with 0 or any value above NUM_LINES meaning NUM_LINES. Commands and completions on lines at or above the active count are ignored.
- R10: `lrst_valid` clears the armed and request flags of `lrst_line` only. It wins over a command on that line in the same cycle, and it leaves the pointer and lock unchanged.
- R11: A search that finds no request leaves the pointer unchanged and raises no `irq`. After a command-triggered search, the lock stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_active | input | CW | Active line count (0 or above NUM_LINES means NUM_LINES) |
| cmd_valid | input | 1 | Transmit command strobe |
| cmd_op | input | 2 | 01 send, 10 stop, others ignored |
| cmd_line | input | LW | Line addressed by the command |
| done_valid | input | 1 | Character-complete strobe |
| done_line | input | LW | Line whose character completed |
| lrst_valid | input | 1 | Per-line flag reset strobe |
| lrst_line | input | LW | Line to reset |
| rd_en | input | 1 | Host read strobe; clears the pointed line's request |
| rd_data | output | 8 | 0x40 OR pointer |
| irq | output | 1 | One-cycle transmit interrupt pulse |

## Verification
A directed sequence arms four lines and takes the lock on one of them. It then raises the other three requests out of order while locked. Each read-and-send step must return them in ascending order after the pointer. This separates true round-robin selection from lowest-index or most-recent selection, and it shows that the lock survives both completions and reads.

Other directed cases cover:
- a reduced active count, where the pointer lies beyond the count and the search must wrap to line 0;
- a completion on a line above the count, which must be ignored;
- a stop command followed by a completion on the now-unarmed line;
- a per-line reset while the lock is held.

A long seeded random run then mixes every strobe, including same-cycle collisions and changes to the active count. It is checked each cycle against a bench model of the flags, pointer and lock.

// File: rtl/txirq_scan_pkg.sv
package txirq_scan_pkg;
  localparam int MAX_LINES = 64;
  localparam logic [7:0] RD_MARK = 8'h40;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SEND = 2'b01,
    OP_STOP = 2'b10,
    OP_RSVD = 2'b11
  } tx_op_e;
endpackage

// File: rtl/txirq_flag_bank.sv
module txirq_flag_bank #(
  parameter int NUM_LINES = 8,
  parameter int LW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lrst_hit,
  input  logic [LW-1:0]        lrst_line,
  input  logic                 cmd_hit,
  input  logic                 cmd_send,
  input  logic [LW-1:0]        cmd_line,
  input  logic                 done_hit,
  input  logic [LW-1:0]        done_line,
  input  logic                 rd_hit,
  input  logic [LW-1:0]        rd_line,
  output logic [NUM_LINES-1:0] armed_q,
  output logic [NUM_LINES-1:0] req_q,
  output logic [NUM_LINES-1:0] req_nxt
);
  logic [NUM_LINES-1:0] armed_nxt;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb begin
      armed_nxt[i] = armed_q[i];
      req_nxt[i]   = req_q[i];
      if (lrst_hit && lrst_line == LW'(i)) begin
        armed_nxt[i] = 1'b0;
        req_nxt[i]   = 1'b0;
      end else if (cmd_hit && cmd_line == LW'(i)) begin
        armed_nxt[i] = cmd_send;
        req_nxt[i]   = 1'b0;
      end else if (done_hit && done_line == LW'(i) && armed_q[i]) begin
        req_nxt[i] = 1'b1;
      end else if (rd_hit && rd_line == LW'(i)) begin
        req_nxt[i] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed_q[i] <= 1'b0;
        req_q[i]   <= 1'b0;
      end else begin
        armed_q[i] <= armed_nxt[i];
        req_q[i]   <= req_nxt[i];
      end
    end
  end
endmodule

// File: rtl/txirq_rr_finder.sv
module txirq_rr_finder #(
  parameter int NUM_LINES = 8,
  parameter int LW = 3,
  parameter int CW = 4
) (
  input  logic [NUM_LINES-1:0] req,
  input  logic [LW-1:0]        start,
  input  logic [CW-1:0]        cnt,
  output logic                 found,
  output logic [LW-1:0]        idx
);
  logic [LW-1:0] p;

  always_comb begin
    found = 1'b0;
    idx   = start;
    p     = start;
    for (int k = 0; k < NUM_LINES; k++) begin
      if (CW'(k) < cnt) begin
        if (CW'(p) + CW'(1) >= cnt) p = '0;
        else                        p = p + LW'(1);
        if (!found && req[p]) begin
          found = 1'b1;
          idx   = p;
        end
      end
    end
  end
endmodule

// File: rtl/txirq_scanner.sv
module txirq_scanner #(
  parameter int NUM_LINES = 8,
  localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CW = $clog2(NUM_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] num_active,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [LW-1:0] cmd_line,
  input  logic          done_valid,
  input  logic [LW-1:0] done_line,
  input  logic          lrst_valid,
  input  logic [LW-1:0] lrst_line,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          irq
);
  import txirq_scan_pkg::*;

  logic [LW-1:0]        ptr_q;
  logic                 lock_q;
  logic [CW-1:0]        cnt_eff;
  logic                 cmd_known, cmd_ok, done_ok, done_scan, scan_go;
  logic [NUM_LINES-1:0] armed_q, req_q, req_nxt;
  logic                 hit_found;
  logic [LW-1:0]        hit_idx;

  assign cnt_eff   = (num_active == '0 || num_active > CW'(NUM_LINES))
                     ? CW'(NUM_LINES) : num_active;
  assign cmd_known = (cmd_op == OP_SEND) || (cmd_op == OP_STOP);
  assign cmd_ok    = cmd_valid && cmd_known && (CW'(cmd_line) < cnt_eff);
  assign done_ok   = done_valid && (CW'(done_line) < cnt_eff);
  assign done_scan = done_ok && armed_q[done_line];
  assign scan_go   = cmd_ok || (done_scan && !lock_q);

  txirq_flag_bank #(.NUM_LINES(NUM_LINES), .LW(LW)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lrst_hit  (lrst_valid),
    .lrst_line (lrst_line),
    .cmd_hit   (cmd_ok),
    .cmd_send  (cmd_op == OP_SEND),
    .cmd_line  (cmd_line),
    .done_hit  (done_ok),
    .done_line (done_line),
    .rd_hit    (rd_en),
    .rd_line   (ptr_q),
    .armed_q   (armed_q),
    .req_q     (req_q),
    .req_nxt   (req_nxt)
  );

  txirq_rr_finder #(.NUM_LINES(NUM_LINES), .LW(LW), .CW(CW)) u_find (
    .req   (req_nxt),
    .start (ptr_q),
    .cnt   (cnt_eff),
    .found (hit_found),
    .idx   (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lock_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (scan_go) begin
        if (hit_found) begin
          ptr_q  <= hit_idx;
          lock_q <= 1'b1;
          irq    <= 1'b1;
        end else if (cmd_ok) begin
          lock_q <= 1'b0;
        end
      end
    end
  end

  assign rd_data = RD_MARK | 8'(ptr_q);
endmodule

// File: rtl/txirq_scanner_checks.sv
module txirq_scanner_checks #(
  parameter int NUM_LINES = 8,
  parameter int LW = 3,
  parameter int CW = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [CW-1:0]        num_active,
  input logic                 cmd_valid,
  input logic [1:0]           cmd_op,
  input logic [LW-1:0]        cmd_line,
  input logic                 done_valid,
  input logic                 lrst_valid,
  input logic                 rd_en,
  input logic                 irq,
  input logic                 lock_q,
  input logic [LW-1:0]        ptr_q,
  input logic [NUM_LINES-1:0] req_q,
  input logic [NUM_LINES-1:0] armed_q
);
  // R6: a pulse only accompanies a held lock on a requesting line
  assert_irq_with_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (lock_q && req_q[ptr_q]));

  // R7: without a command the lock cannot drop
  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cmd_valid) |=> lock_q);

  // R8: a plain read clears the request of the line it pointed at
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !done_valid && !lrst_valid) |=> !req_q[$past(ptr_q)]);

  // R2: an in-range send arms its line
  assert_send_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01 && !lrst_valid && num_active <= CW'(NUM_LINES)
     && CW'(cmd_line) < num_active) |=> armed_q[$past(cmd_line)]);

  // R1: state is clear in the first cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq && !lock_q && req_q == '0 && armed_q == '0));
endmodule

bind txirq_scanner txirq_scanner_checks #(.NUM_LINES(NUM_LINES), .LW(LW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .num_active (num_active),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .cmd_line   (cmd_line),
  .done_valid (done_valid),
  .lrst_valid (lrst_valid),
  .rd_en      (rd_en),
  .irq        (irq),
  .lock_q     (lock_q),
  .ptr_q      (ptr_q),
  .req_q      (req_q),
  .armed_q    (armed_q)
);

// File: tb/txirq_scanner_test.sv
`timescale 1ns/1ps
module txirq_scanner_test;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] num_active;
  logic          cmd_valid, done_valid, lrst_valid, rd_en;
  logic [1:0]    cmd_op;
  logic [LW-1:0] cmd_line, done_line, lrst_line;
  logic [7:0]    rd_data;
  logic          irq;

  always #2 clk = ~clk;

  txirq_scanner #(.NUM_LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .num_active(num_active),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_line(cmd_line),
    .done_valid(done_valid), .done_line(done_line),
    .lrst_valid(lrst_valid), .lrst_line(lrst_line),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_arm, m_req;
  int   m_ptr;
  logic m_lock, m_irq;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int na);
    return (na == 0 || na > N) ? N : na;
  endfunction

  function automatic int find(input logic [N-1:0] rq, input int start, input int c);
    int p = start;
    for (int k = 0; k < c; k++) begin
      p = (p + 1 >= c) ? 0 : p + 1;
      if (rq[p]) return p;
    end
    return -1;
  endfunction

  task automatic step(input logic cv, input logic [1:0] op, input int cl,
                      input logic dv, input int dl, input logic rd,
                      input logic lv, input int ll, input string tag);
    int c, f;
    logic cmd_ok, done_ok, dscan;
    logic [N-1:0] na, nr;
    cmd_valid = cv; cmd_op = op; cmd_line = LW'(cl);
    done_valid = dv; done_line = LW'(dl); rd_en = rd;
    lrst_valid = lv; lrst_line = LW'(ll);
    c = eff(int'(num_active));
    cmd_ok  = cv && (op == 2'b01 || op == 2'b10) && cl < c;
    done_ok = dv && dl < c;
    dscan   = done_ok && m_arm[dl];
    na = m_arm; nr = m_req;
    for (int i = 0; i < N; i++) begin
      if (lv && i == ll) begin na[i] = 0; nr[i] = 0; end
      else if (cmd_ok && i == cl) begin na[i] = (op == 2'b01); nr[i] = 0; end
      else if (done_ok && i == dl && m_arm[i]) nr[i] = 1;
      else if (rd && i == m_ptr) nr[i] = 0;
    end
    m_irq = 1'b0;
    if (cmd_ok || (dscan && !m_lock)) begin
      f = find(nr, m_ptr, c);
      if (f >= 0) begin m_ptr = f; m_lock = 1; m_irq = 1; end
      else if (cmd_ok) m_lock = 0;
    end
    m_arm = na; m_req = nr;
    @(posedge clk); #1;
    chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
    chk({tag, " rd_data"}, rd_data, 8'h40 | 8'(m_ptr));
    cmd_valid = 0; done_valid = 0; rd_en = 0; lrst_valid = 0;
  endtask

  task automatic idle(input string tag);
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; num_active = CW'(8);
    cmd_valid = 0; cmd_op = 0; cmd_line = 0; done_valid = 0; done_line = 0;
    lrst_valid = 0; lrst_line = 0; rd_en = 0;
    m_arm = '0; m_req = '0; m_ptr = 0; m_lock = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    chk("R1 reset rd_data", rd_data, 8'h40);

    // Ascending service order after the pointer (R2 R4 R5 R6 R7 R8)
    step(1, 2'b01, 0, 0, 0, 0, 0, 0, "R2 send0");
    step(1, 2'b01, 2, 0, 0, 0, 0, 0, "R2 send2");
    step(1, 2'b01, 5, 0, 0, 0, 0, 0, "R2 send5");
    step(1, 2'b01, 6, 0, 0, 0, 0, 0, "R2 send6");
    step(0, 2'b00, 0, 1, 0, 0, 0, 0, "R4 done0");
    chk("R6 lock line0 pulse", {7'd0, irq}, 8'h01);
    idle("R6 pulse ends");
    chk("R6 single cycle", {7'd0, irq}, 8'h00);
    step(0, 2'b00, 0, 1, 6, 0, 0, 0, "R7 done6 locked");
    step(0, 2'b00, 0, 1, 2, 0, 0, 0, "R7 done2 locked");
    step(0, 2'b00, 0, 1, 5, 0, 0, 0, "R7 done5 locked");
    chk("R7 pointer held", rd_data, 8'h40);
    step(0, 2'b00, 0, 0, 0, 1, 0, 0, "R8 read0");
    chk("R7 read keeps pointer", rd_data, 8'h40);
    step(1, 2'b01, 0, 0, 0, 0, 0, 0, "R5 next");
    chk("R5 first after pointer", rd_data, 8'h42);
    step(0, 2'b00, 0, 0, 0, 1, 0, 0, "R8 read2");
    step(1, 2'b01, 2, 0, 0, 0, 0, 0, "R5 next");
    chk("R5 second", rd_data, 8'h45);
    step(0, 2'b00, 0, 0, 0, 1, 0, 0, "R8 read5");
    step(1, 2'b01, 5, 0, 0, 0, 0, 0, "R5 next");
    chk("R5 third", rd_data, 8'h46);
    step(0, 2'b00, 0, 0, 0, 1, 0, 0, "R8 read6");
    step(1, 2'b01, 6, 0, 0, 0, 0, 0, "R11 empty");
    chk("R11 no pulse", {7'd0, irq}, 8'h00);
    chk("R11 pointer kept", rd_data, 8'h46);

    // Stop and ignored op codes (R3 R4)
    step(0, 2'b00, 0, 1, 6, 0, 0, 0, "R5 full cycle");
    chk("R5 own line last", rd_data, 8'h46);
    step(1, 2'b10, 6, 0, 0, 0, 0, 0, "R3 stop6");
    step(0, 2'b00, 0, 1, 6, 0, 0, 0, "R3 done after stop");
    chk("R4 unarmed no pulse", {7'd0, irq}, 8'h00);
    step(1, 2'b11, 6, 0, 0, 0, 0, 0, "R3 op11 ignored");
    step(0, 2'b00, 0, 1, 6, 0, 0, 0, "R3 still unarmed");
    chk("R3 op11 no arm", {7'd0, irq}, 8'h00);

    // Reduced count and wrap (R9 R5)
    num_active = CW'(4);
    step(0, 2'b00, 0, 1, 5, 0, 0, 0, "R9 done line5");
    chk("R9 out of range", {7'd0, irq}, 8'h00);
    step(1, 2'b01, 3, 0, 0, 0, 0, 0, "R2 send3");
    step(1, 2'b01, 1, 0, 0, 0, 0, 0, "R2 send1");
    step(0, 2'b00, 0, 1, 3, 0, 0, 0, "R5 wrap from high ptr");
    chk("R5 pointer beyond count", rd_data, 8'h43);
    step(0, 2'b00, 0, 0, 0, 1, 0, 0, "R8 read3");
    step(1, 2'b01, 3, 0, 0, 0, 0, 0, "R11 unlock");
    step(0, 2'b00, 0, 1, 1, 0, 0, 0, "R5 wrap to low");
    chk("R5 wrapped line1", rd_data, 8'h41);

    // Per-line reset while locked (R10)
    step(0, 2'b00, 0, 0, 0, 0, 1, 1, "R10 lrst1");
    step(0, 2'b00, 0, 1, 3, 0, 0, 0, "R10 still locked");
    chk("R10 lock kept", {7'd0, irq}, 8'h00);
    step(1, 2'b01, 2, 0, 0, 0, 0, 0, "R10 unlock");
    chk("R10 finds line3", rd_data, 8'h43);
    step(0, 2'b00, 0, 0, 0, 1, 0, 0, "R8 read3b");
    step(1, 2'b01, 3, 0, 0, 0, 0, 0, "R10 unlock2");
    step(0, 2'b00, 0, 1, 1, 0, 0, 0, "R10 line1 disarmed");
    chk("R10 reset line quiet", {7'd0, irq}, 8'h00);

    // Seeded random mix against the model (all requirements)
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) num_active = CW'($urandom % 10);
      step(($urandom % 4) == 0, 2'($urandom), int'($urandom % N),
           ($urandom % 3) == 0, int'($urandom % N),
           ($urandom % 5) == 0, ($urandom % 40) == 0, int'($urandom % N),
           "R5 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule